// File: doc/BRIEF.md
# SD Multi-Block Data Transfer Engine

This block moves a run of data blocks across the DAT lines of an SD card bus, in 1-bit or 4-bit mode and in either direction. One bus bit time equals one clock cycle of `clk`. The command line, the bus clock divider and any memory addressing belong to neighbouring blocks. A transfer is started by a one-cycle `start` pulse. At that pulse the engine samples its settings: the direction flags, the lane width, the per-block bit count, the repeat count, the write turnaround gap and the expected CRC status token. It keeps those settings until the transfer ends.

On a write, the engine fetches 32-bit words from the host, one word per `wr_take` pulse. It frames each block with a start bit, the payload, one CRC16 per active lane and an end bit. It then releases the bus, reads the card's 3-bit CRC status token and waits out the busy period. On a read, it waits for a start bit, unpacks the payload into 32-bit words and checks each lane's CRC. When the last block is finished it pulses `done` and sets the CRC-OK bit for the direction it ran.

Top module: `sd_blk_mover`

## Requirements
- R1: After reset, `busy`, `done`, `rd_valid`, `wr_take`, `rd_crc_ok` and `wr_crc_ok` are 0 and `dat_oe` is 4'b0000.
- R2: On a write, each block drives a start bit of 0 on every active lane. The payload follows, most significant bit of each word first; in 4-bit mode DAT3 carries the highest bit of each nibble. Each lane then carries its own CRC16 (x^16+x^12+x^5+1, zero seed, MSB first), then an end bit of 1. `dat_oe` is 4'b1111 in 4-bit mode and 4'b0001 in 1-bit mode (`wide` = 1 / 0).
- R3: The payload-plus-CRC part of a block lasts `blk_bits`+1 cycles in 1-bit mode and `blk_bits`/4+1 cycles in 4-bit mode. The payload is therefore `blk_bits` minus 15 per active lane, and it must be a multiple of 32 bits.
- R4: A transfer moves exactly `repeat_cnt`+1 blocks, after which the engine is idle with the bus released.
- R5: After a write block's end bit, the engine releases the bus and waits for a 0 on DAT0. It takes the next three DAT0 bits, first bit as MSB, as the status token. `wr_crc_ok` is set at completion only if every block's token equals `crc_tok`.
- R6: After the token's end bit, the engine waits while DAT0 is 0. The next block's start bit appears `nwr_gap`+1 cycles after the first cycle in which DAT0 is sampled high. After the last block, `done` appears one cycle after that sample, with `busy` low.
- R7: A read block begins only after DAT0 is 0 (1-bit mode) or all four lanes are 0 (4-bit mode). DAT0 alone going low in 4-bit mode does not start a block.
- R8: On a read, each 32 received payload bits are presented on `rd_data` for one cycle with `rd_valid` high, most significant bit received first.
- R9: `rd_crc_ok` is set at read completion only if, in every block, the received CRC16 of every active lane matched its payload.
- R10: `start` is ignored unless exactly one of `is_write` and `is_read` is 1.
- R11: Both CRC-OK bits clear when a transfer is accepted; at most one of them is ever set; `done` is a single-cycle pulse.
- R12: A write transfer issues exactly one `wr_take` per 32 payload bits, and takes `wr_data` in the cycle `wr_take` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus bit time per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle transfer request |
| is_write | input | 1 | Transfer is a write data phase |
| is_read | input | 1 | Transfer is a response followed by read data |
| wide | input | 1 | 0 = 1-bit bus, 1 = 4-bit bus |
| blk_bits | input | 14 | Bits per block: payload plus 15 per lane |
| repeat_cnt | input | 8 | Number of blocks minus one |
| nwr_gap | input | 6 | Idle cycles before the next write block |
| crc_tok | input | 3 | Expected write CRC status token |
| wr_data | input | 32 | Host write word |
| wr_take | output | 1 | `wr_data` consumed this cycle |
| rd_data | output | 32 | Received word |
| rd_valid | output | 1 | `rd_data` holds a new word |
| dat_i | input | 4 | DAT lanes from the card |
| dat_o | output | 4 | DAT lanes to the card |
| dat_oe | output | 4 | Per-lane output enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished pulse |
| rd_crc_ok | output | 1 | Last read had no CRC error |
| wr_crc_ok | output | 1 | Last write got only good tokens |

## Verification
The hardest situations to reach are a CRC error on a lane other than DAT0 in a later block of a read, and a lone DAT0 start bit in 4-bit mode that must not open a block. The bench models the card one bus cycle at a time. It drives each lane from a bench-computed bit stream and CRC, flips a single CRC bit in a chosen lane and block, and holds DAT0 low with the other lanes high before a real start. Any false start would shift every following word. On writes, the card model answers with a chosen token and busy length, and it counts the cycles from the release of DAT0 to the next start bit.

// File: rtl/sdbm_pkg.sv
package sdbm_pkg;
  localparam int LANES = 4;
  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_BODY, S_ENDB, S_TOKW, S_TOK, S_TOKE, S_BUSYW, S_GAP
  } st_t;
endpackage

// File: rtl/sdbm_crc_lane.sv
module sdbm_crc_lane
  import sdbm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic             shift_out,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);
  logic [CRC_W-1:0] crc_n;
  logic             en;
  logic             fb;

  always_comb begin
    fb    = din ^ crc[CRC_W-1];
    en    = clr | upd | shift_out;
    crc_n = crc;
    if (clr)            crc_n = '0;
    else if (upd)       crc_n = {crc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    else if (shift_out) crc_n = {crc[CRC_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  crc <= '0;
    else if (en) crc <= crc_n;
  end

  p_seed_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == '0));
endmodule

// File: rtl/sdbm_shifter.sv
module sdbm_shifter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  input  logic         shift,
  input  logic         wide,
  input  logic [3:0]   din,
  output logic [W-1:0] q
);
  logic [W-1:0] q_n;
  logic         en;

  always_comb begin
    en  = load | shift;
    q_n = q;
    if (load)       q_n = ld_val;
    else if (shift) q_n = wide ? {q[W-5:0], din} : {q[W-2:0], din[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= q_n;
  end
endmodule

// File: rtl/sd_blk_mover.sv
module sd_blk_mover
  import sdbm_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 14,
  parameter int REP_W  = 8,
  parameter int GAP_W  = 6,
  parameter int TOK_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_write,
  input  logic              is_read,
  input  logic              wide,
  input  logic [CNT_W-1:0]  blk_bits,
  input  logic [REP_W-1:0]  repeat_cnt,
  input  logic [GAP_W-1:0]  nwr_gap,
  input  logic [TOK_W-1:0]  crc_tok,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_take,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic [3:0]        dat_i,
  output logic [3:0]        dat_o,
  output logic [3:0]        dat_oe,
  output logic              busy,
  output logic              done,
  output logic              rd_crc_ok,
  output logic              wr_crc_ok
);
  localparam int WC_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CRC_LAST = CNT_W'(CRC_W - 1);
  localparam logic [CNT_W-1:0] PAY_LAST = CNT_W'(CRC_W);
  localparam logic [WC_W-1:0]  WC_END1  = WC_W'(WORD_W - 1);
  localparam logic [WC_W-1:0]  WC_END4  = WC_W'(WORD_W / 4 - 1);
  localparam int TK_W = $clog2(TOK_W);

  st_t              st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n, blk_q;
  logic [WC_W-1:0]  wc, wc_n;
  logic [REP_W-1:0] bk, bk_n, rep_q;
  logic [GAP_W-1:0] g, g_n, gap_q;
  logic [TOK_W-1:0] tk, tk_n, tok_q;
  logic [TK_W-1:0]  k, k_n;
  logic             err, err_n, done_n, rdv_n;
  logic             wr_q, wide_q;
  logic             go, ld, shf, clr, upd, crc_sh;
  logic             wc_last, sbit, crc_bad, pay_phase;
  logic [3:0]       pay_bits, crc_msb, crc_din;
  logic [WORD_W-1:0] q;
  logic [CRC_W-1:0] crc_v [LANES];

  assign go        = (st == S_IDLE) && start && (is_write ^ is_read);
  assign wc_last   = wide_q ? (wc == WC_END4) : (wc == WC_END1);
  assign sbit      = wide_q ? (dat_i == 4'b0000) : !dat_i[0];
  assign pay_phase = (cnt > CRC_LAST);
  assign pay_bits  = wide_q ? q[WORD_W-1 -: 4] : {3'b111, q[WORD_W-1]};
  assign busy      = (st != S_IDLE);
  assign rd_data   = q;
  assign upd       = (st == S_BODY) && (!wr_q || pay_phase);
  assign crc_sh    = (st == S_BODY) && wr_q && !pay_phase;

  sdbm_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(ld), .ld_val(wr_data), .shift(shf),
    .wide(wide_q), .din(dat_i), .q(q)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign crc_din[i] = wr_q ? pay_bits[i] : dat_i[i];
    assign crc_msb[i] = crc_v[i][CRC_W-1];
    sdbm_crc_lane u_crc (
      .clk(clk), .rst_n(rst_n), .clr(clr), .upd(upd), .shift_out(crc_sh),
      .din(crc_din[i]), .crc(crc_v[i])
    );
  end

  always_comb begin
    crc_bad = (crc_v[0] != '0);
    if (wide_q)
      for (int i = 1; i < LANES; i++) crc_bad = crc_bad | (crc_v[i] != '0);
  end

  // Bus drive: only during the framed part of a write block
  always_comb begin
    dat_o  = 4'hF;
    dat_oe = 4'h0;
    if (wr_q && (st == S_START || st == S_BODY || st == S_ENDB)) begin
      dat_oe = wide_q ? 4'hF : 4'h1;
      if (st == S_START)     dat_o = 4'h0;
      else if (st == S_BODY) dat_o = pay_phase ? pay_bits : crc_msb;
    end
  end

  // Next-state process
  always_comb begin
    st_n = st; cnt_n = cnt; wc_n = wc; bk_n = bk; g_n = g; tk_n = tk; k_n = k;
    err_n = err; done_n = 1'b0; rdv_n = 1'b0;
    wr_take = 1'b0; ld = 1'b0; shf = 1'b0; clr = 1'b0;
    case (st)
      S_IDLE: if (go) begin
        st_n = S_START; bk_n = '0; err_n = 1'b0;
      end
      S_START: if (wr_q || sbit) begin
        clr = 1'b1; wc_n = '0; st_n = S_BODY;
        cnt_n = wide_q ? (blk_q >> 2) : blk_q;
        if (wr_q) begin wr_take = 1'b1; ld = 1'b1; end
      end
      S_BODY: begin
        if (pay_phase) begin
          shf  = 1'b1;
          wc_n = wc_last ? '0 : wc + 1'b1;
          if (wc_last) begin
            if (!wr_q)               rdv_n = 1'b1;
            else if (cnt > PAY_LAST) begin wr_take = 1'b1; ld = 1'b1; end
          end
        end
        if (cnt == '0) st_n = S_ENDB;
        else           cnt_n = cnt - 1'b1;
      end
      S_ENDB: if (wr_q) st_n = S_TOKW;
      else begin
        if (crc_bad) err_n = 1'b1;
        if (bk == rep_q) begin st_n = S_IDLE; done_n = 1'b1; end
        else begin bk_n = bk + 1'b1; st_n = S_START; end
      end
      S_TOKW: if (!dat_i[0]) begin st_n = S_TOK; k_n = '0; end
      S_TOK: begin
        tk_n = {tk[TOK_W-2:0], dat_i[0]};
        if (k == TK_W'(TOK_W - 1)) st_n = S_TOKE;
        else                       k_n = k + 1'b1;
      end
      S_TOKE: begin
        if (tk != tok_q) err_n = 1'b1;
        st_n = S_BUSYW;
      end
      S_BUSYW: if (dat_i[0]) begin
        if (bk == rep_q) begin st_n = S_IDLE; done_n = 1'b1; end
        else begin
          bk_n = bk + 1'b1;
          if (gap_q == '0) st_n = S_START;
          else begin g_n = GAP_W'(1); st_n = S_GAP; end
        end
      end
      S_GAP: if (g == gap_q) st_n = S_START;
      else g_n = g + 1'b1;
      default: st_n = S_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; wc <= '0; bk <= '0; g <= '0; tk <= '0; k <= '0;
      err <= 1'b0; done <= 1'b0; rd_valid <= 1'b0; rd_crc_ok <= 1'b0;
      wr_crc_ok <= 1'b0; wr_q <= 1'b0; wide_q <= 1'b0; blk_q <= '0;
      rep_q <= '0; gap_q <= '0; tok_q <= '0;
    end else begin
      st <= st_n; cnt <= cnt_n; wc <= wc_n; bk <= bk_n; g <= g_n;
      tk <= tk_n; k <= k_n; err <= err_n; done <= done_n; rd_valid <= rdv_n;
      if (go) begin
        wr_q <= is_write; wide_q <= wide; blk_q <= blk_bits;
        rep_q <= repeat_cnt; gap_q <= nwr_gap; tok_q <= crc_tok;
        rd_crc_ok <= 1'b0; wr_crc_ok <= 1'b0;
      end else if (done_n) begin
        rd_crc_ok <= !wr_q && !err_n;
        wr_crc_ok <= wr_q && !err_n;
      end
    end
  end

  p_oe_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_oe == 4'h0) || (dat_oe == 4'h1) || (dat_oe == 4'hF));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_ok_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_crc_ok && wr_crc_ok));
  p_take_on_bus_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> dat_oe[0]);
  p_rdvalid_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (dat_oe == 4'h0));
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/sim_sd_blk_mover.sv
module sim_sd_blk_mover;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, is_write, is_read, wide;
  logic [13:0] blk_bits;
  logic [7:0]  repeat_cnt;
  logic [5:0]  nwr_gap;
  logic [2:0]  crc_tok;
  logic [31:0] wr_data, rd_data;
  logic        wr_take, rd_valid, busy, done, rd_crc_ok, wr_crc_ok;
  logic [3:0]  dat_i, dat_o, dat_oe;

  int n_tests = 0, n_fail = 0;
  int widx;
  int r_got, r_badw, r_dones;

  always #4 clk = ~clk;

  function automatic logic [31:0] wgen(int i);
    logic [31:0] v = 32'(i) * 32'h9E3779B1 + 32'h0F1E2D3C;
    return v ^ (v >> 13);
  endfunction

  function automatic logic exp_bit(int base, int nw, bit wd, int blk, int cyc, int lane);
    int cpw = wd ? 8 : 32;
    int pos = cyc % cpw;
    logic [31:0] w = wgen(base + blk * nw + cyc / cpw);
    if (wd) return w[28 - 4 * pos + lane];
    return w[31 - pos];
  endfunction

  function automatic logic [15:0] crc_step(logic [15:0] c, logic b);
    return {c[14:0], 1'b0} ^ ((b ^ c[15]) ? 16'h1021 : 16'h0000);
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) widx <= 0;
    else if (wr_take) widx <= widx + 1;
  assign wr_data = wgen(widx);

  sd_blk_mover u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write), .is_read(is_read),
    .wide(wide), .blk_bits(blk_bits), .repeat_cnt(repeat_cnt), .nwr_gap(nwr_gap),
    .crc_tok(crc_tok), .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data),
    .rd_valid(rd_valid), .dat_i(dat_i), .dat_o(dat_o), .dat_oe(dat_oe), .busy(busy),
    .done(done), .rd_crc_ok(rd_crc_ok), .wr_crc_ok(wr_crc_ok)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic rtick(int rb);
    @(negedge clk);
    if (rd_valid) begin
      if (rd_data !== wgen(rb + r_got)) r_badw++;
      r_got++;
    end
    if (done) r_dones++;
  endtask

  task automatic t_reset();
    chk(!busy && !done && !rd_valid && !wr_take && !rd_crc_ok && !wr_crc_ok && dat_oe == 4'h0,
        "R1", "reset state", {busy, done, rd_valid, wr_take, rd_crc_ok, wr_crc_ok, dat_oe}, 0);
  endtask

  task automatic t_write(bit wd, int nw, int nb, int gap, logic [2:0] tprog,
                         logic [2:0] tcard, bit exp_ok, int blen);
    int lanes = wd ? 4 : 1;
    int cyc = nw * 32 / lanes;
    logic [3:0] am = wd ? 4'hF : 4'h1;
    logic [15:0] crc [4];
    int base, bad, c;
    @(negedge clk);
    base = widx;
    is_write = 1; is_read = 0; wide = wd; blk_bits = 14'(nw * 32 + 15 * lanes);
    repeat_cnt = 8'(nb - 1); nwr_gap = 6'(gap); crc_tok = tprog; dat_i = 4'hF; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy && !rd_crc_ok && !wr_crc_ok, "R11", "status cleared at accept",
        {busy, rd_crc_ok, wr_crc_ok}, 3'b100);
    for (int b = 0; b < nb; b++) begin
      chk(dat_oe == am && (dat_o & am) == 4'h0, "R2", "start bit", {dat_oe, dat_o}, {am, 4'h0});
      bad = 0;
      for (int L = 0; L < 4; L++) crc[L] = 16'h0;
      for (int j = 0; j < cyc; j++) begin
        @(negedge clk);
        if (dat_oe !== am) bad++;
        for (int L = 0; L < lanes; L++) begin
          logic e = exp_bit(base, nw, wd, b, j, L);
          if (dat_o[L] !== e) bad++;
          crc[L] = crc_step(crc[L], e);
        end
      end
      chk(bad == 0, "R2", "payload bit mismatches", bad, 0);
      bad = 0;
      for (int j = 0; j < 16; j++) begin
        @(negedge clk);
        for (int L = 0; L < lanes; L++) if (dat_o[L] !== crc[L][15 - j]) bad++;
      end
      chk(bad == 0, "R2", "lane CRC16 mismatches", bad, 0);
      @(negedge clk);
      chk(dat_oe == am && (dat_o & am) == am, "R3", "end bit at exact block length",
          {dat_oe, dat_o}, {am, am});
      @(negedge clk);
      chk(dat_oe == 4'h0, "R5", "bus released after end bit", dat_oe, 0);
      @(negedge clk);
      dat_i[0] = 1'b0;
      @(negedge clk);
      for (int t = 2; t >= 0; t--) begin
        dat_i[0] = tcard[t];
        @(negedge clk);
      end
      dat_i[0] = 1'b1;
      @(negedge clk);
      dat_i[0] = 1'b0;
      bad = 0;
      repeat (blen) begin
        @(negedge clk);
        if (dat_oe != 4'h0 || done) bad++;
      end
      chk(bad == 0, "R6", "quiet while DAT0 busy", bad, 0);
      dat_i[0] = 1'b1;
      if (b < nb - 1) begin
        c = 0;
        do begin
          @(negedge clk);
          c++;
        end while (!(dat_oe[0] && !dat_o[0]) && c < 200);
        chk(c == gap + 1, "R6", "cycles from DAT0 high to next start bit", c, gap + 1);
      end else begin
        @(negedge clk);
        chk(done && !busy, "R6", "done one cycle after busy ends", {done, busy}, 2'b10);
      end
    end
    chk(wr_crc_ok == exp_ok && !rd_crc_ok, "R5", "write token status",
        {wr_crc_ok, rd_crc_ok}, {exp_ok, 1'b0});
    chk(widx - base == nw * nb, "R12", "words taken", widx - base, nw * nb);
    repeat (3) @(negedge clk);
    chk(!busy && dat_oe == 4'h0 && !done, "R4", "no block beyond repeat count",
        {busy, dat_oe, done}, 0);
  endtask

  task automatic t_read(bit wd, int nw, int nb, int bad_blk, int bad_lane, bit fake, bit exp_ok);
    int lanes = wd ? 4 : 1;
    int cyc = nw * 32 / lanes;
    int rb = 5000 + nb * 17;
    logic [15:0] crc [4];
    logic [3:0] v;
    r_got = 0; r_badw = 0; r_dones = 0;
    @(negedge clk);
    is_write = 0; is_read = 1; wide = wd; blk_bits = 14'(nw * 32 + 15 * lanes);
    repeat_cnt = 8'(nb - 1); nwr_gap = 6'd2; crc_tok = 3'b010; dat_i = 4'hF; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy && !rd_crc_ok && !wr_crc_ok, "R11", "status cleared at accept",
        {busy, rd_crc_ok, wr_crc_ok}, 3'b100);
    for (int b = 0; b < nb; b++) begin
      dat_i = 4'hF;
      rtick(rb);
      rtick(rb);
      if (fake) begin
        dat_i = 4'b1110;
        repeat (3) rtick(rb);
      end
      dat_i = wd ? 4'h0 : 4'hE;
      rtick(rb);
      for (int L = 0; L < 4; L++) crc[L] = 16'h0;
      for (int j = 0; j < cyc; j++) begin
        v = 4'hF;
        for (int L = 0; L < lanes; L++) begin
          v[L] = exp_bit(rb, nw, wd, b, j, L);
          crc[L] = crc_step(crc[L], v[L]);
        end
        dat_i = v;
        rtick(rb);
      end
      for (int j = 0; j < 16; j++) begin
        v = 4'hF;
        for (int L = 0; L < lanes; L++) begin
          v[L] = crc[L][15 - j];
          if (b == bad_blk && L == bad_lane && j == 5) v[L] = ~v[L];
        end
        dat_i = v;
        rtick(rb);
      end
      dat_i = 4'hF;
      rtick(rb);
    end
    repeat (6) rtick(rb);
    chk(r_badw == 0, "R8", "received word mismatches", r_badw, 0);
    chk(r_got == nw * nb, "R8", "received word count", r_got, nw * nb);
    if (fake) chk(r_badw == 0 && r_got == nw * nb, "R7", "lone DAT0 low did not open a block",
                  r_badw, 0);
    chk(r_dones == 1, "R11", "done pulse count", r_dones, 1);
    chk(rd_crc_ok == exp_ok && !wr_crc_ok, "R9", "read CRC status",
        {rd_crc_ok, wr_crc_ok}, {exp_ok, 1'b0});
    chk(!busy && dat_oe == 4'h0, "R4", "idle after last read block", {busy, dat_oe}, 0);
  endtask

  task automatic t_ignore(bit w, bit r);
    @(negedge clk);
    is_write = w; is_read = r; start = 1;
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
    chk(!busy && dat_oe == 4'h0 && !wr_take && !done, "R10", "start ignored with bad flags",
        {busy, dat_oe, wr_take, done}, 0);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; start = 0; is_write = 0; is_read = 0; wide = 0; blk_bits = '0;
    repeat_cnt = '0; nwr_gap = '0; crc_tok = '0; dat_i = 4'hF;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write(1'b0, 1, 2, 2, 3'b010, 3'b010, 1'b1, 3);
    t_write(1'b1, 2, 3, 0, 3'b010, 3'b010, 1'b1, 1);
    t_write(1'b1, 1, 2, 5, 3'b010, 3'b101, 1'b0, 2);
    t_write(1'b0, 1, 1, 1, 3'b101, 3'b101, 1'b1, 4);
    t_read(1'b0, 2, 2, -1, 0, 1'b0, 1'b1);
    t_read(1'b1, 2, 3, -1, 0, 1'b1, 1'b1);
    t_read(1'b1, 1, 2, 1, 2, 1'b0, 1'b0);
    t_read(1'b0, 1, 1, 0, 0, 1'b0, 1'b0);
    t_ignore(1'b1, 1'b1);
    t_ignore(1'b0, 1'b0);
    t_write(1'b1, 1, 1, 0, 3'b010, 3'b010, 1'b1, 1);
    finish_run();
  end
endmodule